// File: doc/BRIEF.md
# Event Status and Mask Interrupt Aggregator

This block gathers ninety-six single-cycle hardware event pulses into three 32-bit sticky status words and steers them onto three level-sensitive interrupt lines. Event n is held in status word n/32, bit n mod 32. Each bit stays set until software acknowledges it by writing a one to that bit position of its status word. Writing a zero leaves the bit unchanged.

Three mask groups each cover all three status words, so any event can be routed to any combination of the three lines. Line A, driven by group 0, has the highest priority. Line B is driven by group 1 and line C, the lowest, by group 2. A line is high while any event that its group enables is pending.

Next to each line, a 7-bit index gives the lowest-numbered pending event that the group enables. Software reaches the registers over a simple 32-bit bus with a combinational read port and a write strobe.

Top module: `evt_irq_agg`

## Requirements
- R1: A pulse on event input n sets bit n mod 32 of the status word at offset 4*(n/32), for offsets 0x00, 0x04 and 0x08. The bit then stays set until it is acknowledged.
- R2: Writing a status word clears each bit where the write data holds a one. Bits where the data holds a zero keep their value, and a write never sets a status bit.
- R3: If an event pulse and a write-one acknowledge of the same bit fall in the same cycle, the bit stays set.
- R4: Mask group g (0, 1, 2) sits at offsets 0x10*(g+1) + 4*w for word w (0, 1, 2). Each of its registers is read/write and reads back the last value written.
- R5: Line g (bit g of `irq_line`: 0 = A, 1 = B, 2 = C) is high exactly when some status bit is set and the matching bit of group g's mask is also 1. A mask bit of 0 keeps that event off that line.
- R6: While line g is high, its index (bits 7g+6..7g of `irq_idx`) is the lowest event number n that is both pending and enabled by group g. While the line is low, the index is 0.
- R7: After reset, every status bit and every mask bit is 0, all lines are low and all indices are 0.
- R8: A read of any offset outside the twelve above, including an offset with either of the low two address bits set, returns 0. A write to such an offset changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_pulse | input | 96 | One single-cycle pulse per event; bit n is event n |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe, valid while bus_sel is high |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data; 0 when not selected or unmapped |
| irq_line | output | 3 | Level interrupt lines, bit 0 = A (highest priority) |
| irq_idx | output | 21 | Lowest pending enabled event per line, 7 bits per line |

## Verification
The bench sweeps every one of the 96 events through the mask word and line it belongs to. This catches a design that misplaces a word or a bit, because the wrong line or index would show up. Writes that hold zeros in a pending bit's position must leave that bit set. A design that overwrites the status word instead of clearing by ones would lose the event.

An event that arrives in the same cycle as its own acknowledge must survive. A design that gives the clear priority would drop the event for good.

With many events pending under all-ones masks, the bench clears them one at a time. The index must always move up to the next lowest event, which exposes an encoder that favours the highest bit. Writes to unaligned and unmapped offsets must leave every register unchanged, which exposes a decoder that ignores the low address bits.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;

    // Register class selected by a bus offset
    typedef enum logic [1:0] {
        REG_NONE = 2'd0,
        REG_STAT = 2'd1,
        REG_MASK = 2'd2
    } reg_kind_e;

endpackage

// File: rtl/evt_reg_decode.sv
module evt_reg_decode
    import evt_irq_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int NUM_WORDS = 3,
    parameter int NUM_LINES = 3,
    localparam int GRP_W    = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_kind_e         kind,
    output logic [1:0]        word,
    output logic [GRP_W-1:0]  grp
);
    localparam int BLK_W = ADDR_W - 4;

    logic [BLK_W-1:0] blk;
    logic             aligned;
    logic             word_ok;

    assign blk     = addr[ADDR_W-1:4];
    assign word    = addr[3:2];
    assign aligned = (addr[1:0] == 2'b00);
    assign word_ok = (32'(word) < NUM_WORDS);

    // Block 0 holds status words, blocks 1..NUM_LINES hold mask groups
    always_comb begin
        kind = REG_NONE;
        grp  = '0;
        if (aligned && word_ok) begin
            if (blk == '0) begin
                kind = REG_STAT;
            end else if (32'(blk) <= NUM_LINES) begin
                kind = REG_MASK;
                grp  = GRP_W'(32'(blk) - 1);
            end
        end
    end
endmodule

// File: rtl/evt_status_bank.sv
module evt_status_bank #(
    parameter int WORD_W    = 32,
    parameter int NUM_WORDS = 3,
    localparam int NUM_EVT  = WORD_W * NUM_WORDS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EVT-1:0] evt,
    input  logic               clr_en,
    input  logic [1:0]         clr_word,
    input  logic [WORD_W-1:0]  clr_bits,
    output logic [NUM_EVT-1:0] stat_q
);
    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        logic [WORD_W-1:0] word_q;
        logic [WORD_W-1:0] clr_w;

        assign clr_w = (clr_en && (clr_word == 2'(w))) ? clr_bits : '0;

        // New events are OR-ed in after the clear, so an event wins a collision
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                word_q <= '0;
            end else begin
                word_q <= (word_q & ~clr_w) | evt[w*WORD_W +: WORD_W];
            end
        end

        assign stat_q[w*WORD_W +: WORD_W] = word_q;
    end
endmodule

// File: rtl/evt_mask_bank.sv
module evt_mask_bank #(
    parameter int WORD_W    = 32,
    parameter int NUM_WORDS = 3,
    parameter int NUM_LINES = 3,
    localparam int NUM_EVT  = WORD_W * NUM_WORDS,
    localparam int GRP_W    = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [GRP_W-1:0]             wr_grp,
    input  logic [1:0]                   wr_word,
    input  logic [WORD_W-1:0]            wr_data,
    output logic [NUM_LINES*NUM_EVT-1:0] mask_q
);
    for (genvar g = 0; g < NUM_LINES; g++) begin : g_grp
        for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
            logic [WORD_W-1:0] word_q;

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    word_q <= '0;
                end else if (wr_en && (wr_grp == GRP_W'(g)) && (wr_word == 2'(w))) begin
                    word_q <= wr_data;
                end
            end

            assign mask_q[g*NUM_EVT + w*WORD_W +: WORD_W] = word_q;
        end
    end
endmodule

// File: rtl/evt_line_route.sv
module evt_line_route #(
    parameter int NUM_EVT = 96,
    localparam int IDX_W  = $clog2(NUM_EVT)
) (
    input  logic [NUM_EVT-1:0] stat,
    input  logic [NUM_EVT-1:0] mask,
    output logic               line,
    output logic [IDX_W-1:0]   idx
);
    logic [NUM_EVT-1:0] hits;

    assign hits = stat & mask;
    assign line = |hits;

    // Scan from the top down so the lowest set bit is the last one written
    always_comb begin
        idx = '0;
        for (int i = NUM_EVT - 1; i >= 0; i--) begin
            if (hits[i]) begin
                idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/evt_irq_agg.sv
module evt_irq_agg
    import evt_irq_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int WORD_W    = 32,
    parameter int NUM_WORDS = 3,
    parameter int NUM_LINES = 3,
    localparam int NUM_EVT  = WORD_W * NUM_WORDS,
    localparam int IDX_W    = $clog2(NUM_EVT),
    localparam int GRP_W    = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_EVT-1:0]         evt_pulse,
    input  logic                       bus_sel,
    input  logic                       bus_wr,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic [WORD_W-1:0]          bus_wdata,
    output logic [WORD_W-1:0]          bus_rdata,
    output logic [NUM_LINES-1:0]       irq_line,
    output logic [NUM_LINES*IDX_W-1:0] irq_idx
);
    reg_kind_e                    kind;
    logic [1:0]                   word;
    logic [GRP_W-1:0]             grp;
    logic                         wr_en;
    logic [NUM_EVT-1:0]           stat_q;
    logic [NUM_LINES*NUM_EVT-1:0] mask_q;

    assign wr_en = bus_sel && bus_wr;

    evt_reg_decode #(
        .ADDR_W    (ADDR_W),
        .NUM_WORDS (NUM_WORDS),
        .NUM_LINES (NUM_LINES)
    ) u_dec (
        .addr (bus_addr),
        .kind (kind),
        .word (word),
        .grp  (grp)
    );

    evt_status_bank #(
        .WORD_W    (WORD_W),
        .NUM_WORDS (NUM_WORDS)
    ) u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt      (evt_pulse),
        .clr_en   (wr_en && (kind == REG_STAT)),
        .clr_word (word),
        .clr_bits (bus_wdata),
        .stat_q   (stat_q)
    );

    evt_mask_bank #(
        .WORD_W    (WORD_W),
        .NUM_WORDS (NUM_WORDS),
        .NUM_LINES (NUM_LINES)
    ) u_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en && (kind == REG_MASK)),
        .wr_grp  (grp),
        .wr_word (word),
        .wr_data (bus_wdata),
        .mask_q  (mask_q)
    );

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        evt_line_route #(
            .NUM_EVT (NUM_EVT)
        ) u_route (
            .stat (stat_q),
            .mask (mask_q[g*NUM_EVT +: NUM_EVT]),
            .line (irq_line[g]),
            .idx  (irq_idx[g*IDX_W +: IDX_W])
        );
    end

    // Combinational read port
    always_comb begin
        bus_rdata = '0;
        if (bus_sel) begin
            case (kind)
                REG_STAT: bus_rdata = stat_q[32'(word)*WORD_W +: WORD_W];
                REG_MASK: bus_rdata = mask_q[32'(grp)*NUM_EVT + 32'(word)*WORD_W +: WORD_W];
                default:  bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/evt_irq_agg_chk.sv
module evt_irq_agg_chk #(
    parameter int ADDR_W    = 8,
    parameter int WORD_W    = 32,
    parameter int NUM_WORDS = 3,
    parameter int NUM_LINES = 3,
    localparam int NUM_EVT  = WORD_W * NUM_WORDS,
    localparam int IDX_W    = $clog2(NUM_EVT)
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic [NUM_EVT-1:0]           evt_pulse,
    input logic                         bus_sel,
    input logic                         bus_wr,
    input logic [ADDR_W-1:0]            bus_addr,
    input logic [NUM_LINES-1:0]         irq_line,
    input logic [NUM_LINES*IDX_W-1:0]   irq_idx,
    input logic [NUM_EVT-1:0]           stat_q,
    input logic [NUM_LINES*NUM_EVT-1:0] mask_q
);
    logic stat_blk_wr;
    logic mask_blk_wr;

    assign stat_blk_wr = bus_sel && bus_wr && (bus_addr[ADDR_W-1:4] == '0);
    assign mask_blk_wr = bus_sel && bus_wr && (bus_addr[ADDR_W-1:4] != '0);

    AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_blk_wr |=> ((stat_q & $past(stat_q)) == $past(stat_q))); // R1

    AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_pulse) |=> ((stat_q & $past(evt_pulse)) == $past(evt_pulse))); // R3

    AST_NO_WRITE_SET: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((stat_q & ~$past(stat_q) & ~$past(evt_pulse)) == '0)); // R2

    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_blk_wr |=> $stable(mask_q)); // R4

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        logic [NUM_EVT-1:0] mg;
        logic [IDX_W-1:0]   ix;
        logic [NUM_EVT-1:0] below;

        assign mg    = mask_q[g*NUM_EVT +: NUM_EVT];
        assign ix    = irq_idx[g*IDX_W +: IDX_W];
        assign below = (NUM_EVT'(1) << ix) - NUM_EVT'(1);

        AST_LINE_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
            ((stat_q & mg) == '0) |-> !irq_line[g]); // R5

        AST_IDX_HIT: assert property (@(posedge clk) disable iff (!rst_n)
            irq_line[g] |-> ((32'(ix) < NUM_EVT) && stat_q[ix] && mg[ix])); // R6

        AST_IDX_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
            irq_line[g] |-> ((stat_q & mg & below) == '0)); // R6

        AST_IDX_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
            !irq_line[g] |-> (ix == '0)); // R6
    end
endmodule

bind evt_irq_agg evt_irq_agg_chk #(
    .ADDR_W    (ADDR_W),
    .WORD_W    (WORD_W),
    .NUM_WORDS (NUM_WORDS),
    .NUM_LINES (NUM_LINES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_pulse (evt_pulse),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .irq_line  (irq_line),
    .irq_idx   (irq_idx),
    .stat_q    (stat_q),
    .mask_q    (mask_q)
);

// File: tb/evt_irq_agg_tb.sv
`timescale 1ns/100ps
module evt_irq_agg_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [95:0] evt_pulse = '0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [2:0]  irq_line;
    logic [20:0] irq_idx;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    logic [95:0] m_stat = '0;
    logic [95:0] m_mask [3];

    always #2 clk = ~clk;

    evt_irq_agg u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_pulse (evt_pulse),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_line  (irq_line),
        .irq_idx   (irq_idx)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One clock of stimulus; the model follows the requirements
    task automatic step(input logic [95:0] ev, input logic wr,
                        input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        evt_pulse = ev;
        bus_sel = wr;
        bus_wr = wr;
        bus_addr = a;
        bus_wdata = d;
        @(posedge clk);
        #0.5;
        evt_pulse = '0;
        bus_sel = 1'b0;
        bus_wr = 1'b0;
        if (wr && a[1:0] == 2'b00 && a[3:2] < 2'd3) begin
            if (a[7:4] == 4'd0)
                m_stat[32*a[3:2] +: 32] = m_stat[32*a[3:2] +: 32] & ~d;
            else if (a[7:4] <= 4'd3)
                m_mask[a[7:4]-4'd1][32*a[3:2] +: 32] = d;
        end
        m_stat = m_stat | ev;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1;
        bus_wr = 1'b0;
        bus_addr = a;
        #0.5;
        d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic verify_all(input string tag);
        logic [31:0] d;
        logic [95:0] hits;
        logic [6:0]  ix;
        for (int w = 0; w < 3; w++) begin
            rd(8'(4*w), d);
            check({tag, " status"}, d, m_stat[32*w +: 32]);
        end
        for (int g = 0; g < 3; g++) begin
            for (int w = 0; w < 3; w++) begin
                rd(8'(16*(g+1) + 4*w), d);
                check({tag, " mask"}, d, m_mask[g][32*w +: 32]);
            end
        end
        for (int g = 0; g < 3; g++) begin
            hits = m_stat & m_mask[g];
            ix = '0;
            for (int i = 95; i >= 0; i--) if (hits[i]) ix = 7'(i);
            check({tag, " line"}, 32'(irq_line[g]), 32'(|hits));
            check({tag, " index"}, 32'(irq_idx[7*g +: 7]), 32'(ix));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        for (int g = 0; g < 3; g++) m_mask[g] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R7: everything clear after reset
        verify_all("R7 reset");

        // R4: distinct pattern in each mask register
        for (int g = 0; g < 3; g++)
            for (int w = 0; w < 3; w++)
                step('0, 1'b1, 8'(16*(g+1) + 4*w), 32'h5A00_0000 ^ 32'((g << 8) | (w << 4) | 3));
        verify_all("R4 mask readback");
        for (int g = 0; g < 3; g++)
            for (int w = 0; w < 3; w++)
                step('0, 1'b1, 8'(16*(g+1) + 4*w), 32'h0);

        // R1 R5 R6 R2: each event through its own line and word
        for (int n = 0; n < 96; n++) begin
            int g = n % 3;
            int w = n / 32;
            int b = n % 32;
            step('0, 1'b1, 8'(16*(g+1) + 4*w), 32'd1 << b);
            step(96'd1 << n, 1'b0, 8'h00, 32'h0);
            verify_all("R1 R5 R6 single event");
            step('0, 1'b1, 8'(4*w), ~(32'd1 << b));
            verify_all("R2 zero keeps bit");
            step('0, 1'b1, 8'(4*w), 32'd1 << b);
            verify_all("R2 one clears bit");
            step('0, 1'b1, 8'(16*(g+1) + 4*w), 32'h0);
        end

        // R5: pending but masked events stay off the lines
        step((96'd1 << 5) | (96'd1 << 50) | (96'd1 << 90), 1'b0, 8'h00, 32'h0);
        verify_all("R5 blocked");
        step('0, 1'b1, 8'h24, 32'd1 << 18);
        verify_all("R5 single route");

        // R6: all masks open, release events lowest first
        for (int g = 0; g < 3; g++)
            for (int w = 0; w < 3; w++)
                step('0, 1'b1, 8'(16*(g+1) + 4*w), 32'hFFFF_FFFF);
        step((96'd1 << 95) | (96'd1 << 40) | (96'd1 << 7) | (96'd1 << 64), 1'b0, 8'h00, 32'h0);
        while (m_stat != '0) begin
            int low = 0;
            verify_all("R6 priority");
            for (int i = 95; i >= 0; i--) if (m_stat[i]) low = i;
            step('0, 1'b1, 8'(4*(low/32)), 32'd1 << (low % 32));
        end
        verify_all("R6 drained");

        // R3: event and acknowledge of the same bit in one cycle
        step(96'd1 << 33, 1'b1, 8'h04, 32'h0000_0002);
        verify_all("R3 collision");
        step((96'd1 << 34), 1'b1, 8'h04, 32'h0000_0002);
        verify_all("R3 neighbour clear");

        // R8: unmapped and unaligned offsets
        step(96'd1 << 10, 1'b0, 8'h00, 32'h0);
        step('0, 1'b1, 8'h01, 32'hFFFF_FFFF);
        step('0, 1'b1, 8'h0C, 32'hFFFF_FFFF);
        step('0, 1'b1, 8'h11, 32'h0);
        step('0, 1'b1, 8'h1C, 32'h0);
        step('0, 1'b1, 8'h40, 32'h0);
        step('0, 1'b1, 8'h26, 32'h0);
        verify_all("R8 ignored writes");
        rd(8'h0C, d); check("R8 read 0x0C", d, 32'h0);
        rd(8'h1C, d); check("R8 read 0x1C", d, 32'h0);
        rd(8'h40, d); check("R8 read 0x40", d, 32'h0);
        rd(8'h01, d); check("R8 read 0x01", d, 32'h0);
        rd(8'h12, d); check("R8 read 0x12", d, 32'h0);
        rd(8'hFC, d); check("R8 read 0xFC", d, 32'h0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule